// File: doc/BRIEF.md
# Vector Coprocessor Exception Capture Unit

This block sits between a vector coprocessor and its scalar host and holds the first exception the coprocessor raises until the host software has dealt with it. Faults can come from several places: the unit's own check of configuration commands, reads from user mode that need supervisor rights, host-command decode, vector instruction fetch and memory address checks. Each fault carries a 4-bit cause code and an auxiliary word. The meaning of the auxiliary word depends on the cause.

Once a fault is latched, the unit stops accepting vector work. It raises a coprocessor interrupt, which is gated by the host's interrupt mask bit. The host's handler issues commands to read back the cause and the auxiliary word. It then issues a kill, which returns the unit to normal operation.

Top module: `vxcpt_unit`

## Requirements
- R1: The latched cause codes are: 0 bad configuration, 1 bad host instruction, 2 privileged read from user mode, 3 bad register ID in a host vector command, 4 misaligned fetch, 5 fetch fault, 6 bad fetched instruction, 7 bad register ID in a fetched instruction, 8 misaligned load, 9 misaligned store, 10 load fault, 11 store fault. The fetch source selects 4 to 7 with `fet_kind_i` 0 to 3. The memory source selects 8 to 11 with `mem_kind_i` 0 to 3. The decode source gives 1, or gives 3 when `dec_bad_reg_i` is set.
- R2: The auxiliary word depends on the cause. Cause 0 holds a flag, causes 1 to 3 hold the instruction word, causes 4 to 7 hold the fetch PC exactly as given (including unaligned values), and causes 8 to 11 hold the faulting address.
- R3: A configuration command (`cmd_op_i`=0) holds the integer register count in `cmd_cfg_i[5:0]` and the float count in `cmd_cfg_i[11:6]`. A count up to 32 is legal and pulses `cfg_ok_o` in the same cycle. A count of 33 or more raises cause 0, with aux 0 when the integer count is bad (checked first) and aux 1 when only the float count is bad.
- R4: A read-cause (`cmd_op_i`=1) or read-aux (`cmd_op_i`=2) command issued while `host_super_i` is 0 returns no response and raises cause 2, with `cmd_word_i` as aux.
- R5: While an exception is pending, further requests from any source are ignored, and the latched cause and aux stay unchanged.
- R6: When several sources request in the same cycle, the lowest cause code is latched.
- R7: `irq_o` is high exactly while an exception is pending and `host_im_cop_i` is 1.
- R8: A read command in supervisor mode returns `rsp_valid_o`=1 one cycle later. The data is the cause, zero-extended, for read-cause, or the aux word for read-aux.
- R9: A kill command (`cmd_op_i`=3) clears the pending exception on the next edge. After that, new configurations and new exceptions are accepted normally.
- R10: `vec_ready_o` is low while an exception is pending, and configuration commands are ignored during that time (no `cfg_ok_o`).
- R11: After reset, nothing is pending: `irq_o` and `rsp_valid_o` are 0 and `vec_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_op_i | input | 2 | 0 config, 1 read cause, 2 read aux, 3 kill |
| cmd_word_i | input | ILEN | Instruction word of the host command |
| cmd_cfg_i | input | CFG_W | Configuration word |
| host_super_i | input | 1 | Host supervisor bit |
| host_im_cop_i | input | 1 | Host coprocessor interrupt mask bit |
| dec_req_i | input | 1 | Decode fault request |
| dec_bad_reg_i | input | 1 | Decode fault is a bad register ID |
| dec_word_i | input | ILEN | Offending instruction word |
| fet_req_i | input | 1 | Fetch fault request |
| fet_kind_i | input | 2 | Fetch fault kind (cause 4+kind) |
| fet_pc_i | input | AUX_W | Fetch PC |
| mem_req_i | input | 1 | Memory fault request |
| mem_kind_i | input | 2 | Memory fault kind (cause 8+kind) |
| mem_addr_i | input | AUX_W | Faulting address |
| vec_ready_o | output | 1 | Unit accepts vector work |
| cfg_ok_o | output | 1 | Legal configuration accepted |
| irq_o | output | 1 | Masked coprocessor interrupt |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_data_o | output | AUX_W | Read response data |

## Verification
A table raises each of the twelve causes in turn from a single source. For each one the bench reads back the cause and the aux word, which separates the per-cause aux handling: the flag for cause 0, the instruction word for causes 1 to 3, the exact unaligned PC for fetch faults and the address for memory faults. Configuration words are tried at 32/32, at 33 in the integer field only and at 33 in the float field only. These tell the legal bound apart from an off-by-one error and show which flag is chosen. Further stimulus covers:
- three sources requesting in the same cycle, which exposes the priority order;
- a later request while a fault is pending, which shows the first one is held;
- the mask toggled while a fault is pending;
- user-mode reads, which show the privilege trap is taken instead of a response.

// File: rtl/vxcpt_pkg.sv
package vxcpt_pkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    C_BAD_CFG    = 4'd0,
    C_BAD_INSTR  = 4'd1,
    C_PRIV       = 4'd2,
    C_HOST_REGID = 4'd3,
    C_FET_MISAL  = 4'd4,
    C_FET_FAULT  = 4'd5,
    C_FET_INSTR  = 4'd6,
    C_FET_REGID  = 4'd7,
    C_LD_MISAL   = 4'd8,
    C_ST_MISAL   = 4'd9,
    C_LD_FAULT   = 4'd10,
    C_ST_FAULT   = 4'd11
  } cause_e;

  typedef enum logic [1:0] {
    OP_CFG      = 2'd0,
    OP_RD_CAUSE = 2'd1,
    OP_RD_AUX   = 2'd2,
    OP_KILL     = 2'd3
  } op_e;

  localparam int NSRC = 5;
  localparam int SRC_CFG  = 0;
  localparam int SRC_PRIV = 1;
  localparam int SRC_DEC  = 2;
  localparam int SRC_FET  = 3;
  localparam int SRC_MEM  = 4;
endpackage

// File: rtl/vxcpt_cfg_check.sv
module vxcpt_cfg_check #(
  parameter int CFG_W    = 12,
  parameter int NX_W     = 6,
  parameter int MAX_REGS = 32
) (
  input  logic             valid_i,
  input  logic [CFG_W-1:0] word_i,
  output logic             ok_o,
  output logic             bad_o,
  output logic             flag_o
);
  localparam int NF_W = CFG_W - NX_W;

  logic [NX_W-1:0] nx;
  logic [NF_W-1:0] nf;
  logic            nx_bad, nf_bad;

  assign nx     = word_i[NX_W-1:0];
  assign nf     = word_i[CFG_W-1:NX_W];
  assign nx_bad = 32'(nx) > 32'(MAX_REGS);
  assign nf_bad = 32'(nf) > 32'(MAX_REGS);

  assign bad_o  = valid_i && (nx_bad || nf_bad);
  assign ok_o   = valid_i && !nx_bad && !nf_bad;
  // integer field reported first when both are out of range
  assign flag_o = !nx_bad;
endmodule

// File: rtl/vxcpt_arb.sv
module vxcpt_arb
  import vxcpt_pkg::*;
#(
  parameter int NREQ  = 5,
  parameter int AUX_W = 32
) (
  input  logic [NREQ-1:0]              req_i,
  input  logic [NREQ-1:0][CAUSE_W-1:0] cause_i,
  input  logic [NREQ-1:0][AUX_W-1:0]   aux_i,
  output logic                         any_o,
  output logic [CAUSE_W-1:0]           cause_o,
  output logic [AUX_W-1:0]             aux_o
);
  always_comb begin
    any_o   = 1'b0;
    cause_o = '0;
    aux_o   = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_i[i] && (!any_o || cause_i[i] < cause_o)) begin
        any_o   = 1'b1;
        cause_o = cause_i[i];
        aux_o   = aux_i[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      if (req_i[i]) assert_min_cause_R6: assert (any_o && cause_o <= cause_i[i]);
    end
  end
endmodule

// File: rtl/vxcpt_hold.sv
module vxcpt_hold
  import vxcpt_pkg::*;
#(
  parameter int AUX_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [AUX_W-1:0]   aux_i,
  input  logic               kill_i,
  output logic               pending_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [AUX_W-1:0]   aux_o
);
  logic               pending_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [AUX_W-1:0]   aux_q;
  logic               take;

  // kill takes precedence; same-cycle requests are dropped
  assign take = req_i && !pending_q && !kill_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cause_q   <= '0;
      aux_q     <= '0;
    end else if (kill_i) begin
      pending_q <= 1'b0;
    end else if (take) begin
      pending_q <= 1'b1;
      cause_q   <= cause_i;
      aux_q     <= aux_i;
    end
  end

  assign pending_o = pending_q;
  assign cause_o   = cause_q;
  assign aux_o     = aux_q;

  assert_first_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && !kill_i |=> pending_q && $stable(cause_q) && $stable(aux_q));

  assert_kill_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !pending_q);

  assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !pending_q && !kill_i |=> pending_q && cause_q == $past(cause_i));
endmodule

// File: rtl/vxcpt_unit.sv
module vxcpt_unit
  import vxcpt_pkg::*;
#(
  parameter int ILEN     = 32,
  parameter int AUX_W    = 32,
  parameter int CFG_W    = 12,
  parameter int NX_W     = 6,
  parameter int MAX_REGS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [ILEN-1:0]  cmd_word_i,
  input  logic [CFG_W-1:0] cmd_cfg_i,
  input  logic             host_super_i,
  input  logic             host_im_cop_i,
  input  logic             dec_req_i,
  input  logic             dec_bad_reg_i,
  input  logic [ILEN-1:0]  dec_word_i,
  input  logic             fet_req_i,
  input  logic [1:0]       fet_kind_i,
  input  logic [AUX_W-1:0] fet_pc_i,
  input  logic             mem_req_i,
  input  logic [1:0]       mem_kind_i,
  input  logic [AUX_W-1:0] mem_addr_i,
  output logic             vec_ready_o,
  output logic             cfg_ok_o,
  output logic             irq_o,
  output logic             rsp_valid_o,
  output logic [AUX_W-1:0] rsp_data_o
);
  logic is_cfg, is_rd_cause, is_rd_aux, is_kill, is_rd;
  logic pending;
  logic cfg_bad, cfg_flag, cfg_ok;

  logic [NSRC-1:0]              src_req;
  logic [NSRC-1:0][CAUSE_W-1:0] src_cause;
  logic [NSRC-1:0][AUX_W-1:0]   src_aux;

  logic               arb_any;
  logic [CAUSE_W-1:0] arb_cause, held_cause;
  logic [AUX_W-1:0]   arb_aux, held_aux;

  logic             rsp_valid_q;
  logic [AUX_W-1:0] rsp_data_q;

  assign is_cfg      = cmd_valid_i && op_e'(cmd_op_i) == OP_CFG;
  assign is_rd_cause = cmd_valid_i && op_e'(cmd_op_i) == OP_RD_CAUSE;
  assign is_rd_aux   = cmd_valid_i && op_e'(cmd_op_i) == OP_RD_AUX;
  assign is_kill     = cmd_valid_i && op_e'(cmd_op_i) == OP_KILL;
  assign is_rd       = is_rd_cause || is_rd_aux;

  vxcpt_cfg_check #(
    .CFG_W   (CFG_W),
    .NX_W    (NX_W),
    .MAX_REGS(MAX_REGS)
  ) u_cfg (
    .valid_i(is_cfg && !pending),
    .word_i (cmd_cfg_i),
    .ok_o   (cfg_ok),
    .bad_o  (cfg_bad),
    .flag_o (cfg_flag)
  );

  always_comb begin
    src_req   = '0;
    src_cause = '0;
    src_aux   = '0;

    src_req[SRC_CFG]   = cfg_bad;
    src_cause[SRC_CFG] = C_BAD_CFG;
    src_aux[SRC_CFG]   = AUX_W'(cfg_flag);

    src_req[SRC_PRIV]   = is_rd && !host_super_i;
    src_cause[SRC_PRIV] = C_PRIV;
    src_aux[SRC_PRIV]   = AUX_W'(cmd_word_i);

    src_req[SRC_DEC]   = dec_req_i;
    src_cause[SRC_DEC] = dec_bad_reg_i ? C_HOST_REGID : C_BAD_INSTR;
    src_aux[SRC_DEC]   = AUX_W'(dec_word_i);

    src_req[SRC_FET]   = fet_req_i;
    src_cause[SRC_FET] = CAUSE_W'(C_FET_MISAL) + CAUSE_W'(fet_kind_i);
    src_aux[SRC_FET]   = fet_pc_i;

    src_req[SRC_MEM]   = mem_req_i;
    src_cause[SRC_MEM] = CAUSE_W'(C_LD_MISAL) + CAUSE_W'(mem_kind_i);
    src_aux[SRC_MEM]   = mem_addr_i;
  end

  vxcpt_arb #(
    .NREQ (NSRC),
    .AUX_W(AUX_W)
  ) u_arb (
    .req_i  (src_req),
    .cause_i(src_cause),
    .aux_i  (src_aux),
    .any_o  (arb_any),
    .cause_o(arb_cause),
    .aux_o  (arb_aux)
  );

  vxcpt_hold #(
    .AUX_W(AUX_W)
  ) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (arb_any),
    .cause_i  (arb_cause),
    .aux_i    (arb_aux),
    .kill_i   (is_kill),
    .pending_o(pending),
    .cause_o  (held_cause),
    .aux_o    (held_aux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= is_rd && host_super_i;
      if (is_rd && host_super_i)
        rsp_data_q <= is_rd_cause ? AUX_W'(held_cause) : held_aux;
    end
  end

  assign vec_ready_o = !pending;
  assign cfg_ok_o    = cfg_ok;
  assign irq_o       = pending && host_im_cop_i;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  assert_busy_when_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !vec_ready_o && !cfg_ok_o);

  assert_rsp_needs_super_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(host_super_i) && $past(cmd_valid_i));

  assert_user_read_traps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd && !host_super_i |=> !rsp_valid_o && !vec_ready_o);
endmodule

// File: tb/sim_vxcpt_unit.sv
module sim_vxcpt_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_word = '0;
  logic [11:0] cmd_cfg = '0;
  logic        host_super = 1'b1;
  logic        host_im = 1'b1;
  logic        dec_req = 1'b0, dec_bad_reg = 1'b0;
  logic [31:0] dec_word = '0;
  logic        fet_req = 1'b0;
  logic [1:0]  fet_kind = '0;
  logic [31:0] fet_pc = '0;
  logic        mem_req = 1'b0;
  logic [1:0]  mem_kind = '0;
  logic [31:0] mem_addr = '0;
  logic        vec_ready, cfg_ok, irq, rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vxcpt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_word_i(cmd_word),
    .cmd_cfg_i(cmd_cfg), .host_super_i(host_super), .host_im_cop_i(host_im),
    .dec_req_i(dec_req), .dec_bad_reg_i(dec_bad_reg), .dec_word_i(dec_word),
    .fet_req_i(fet_req), .fet_kind_i(fet_kind), .fet_pc_i(fet_pc),
    .mem_req_i(mem_req), .mem_kind_i(mem_kind), .mem_addr_i(mem_addr),
    .vec_ready_o(vec_ready), .cfg_ok_o(cfg_ok), .irq_o(irq),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  // src: 0 cfg, 1 user read, 2 decode, 3 fetch, 4 memory
  typedef struct packed {
    logic [2:0]  src;
    logic [1:0]  kind;
    logic [31:0] arg;
    logic [3:0]  exp_cause;
    logic [31:0] exp_aux;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{3'd0, 2'd0, 32'd33,                 4'd0,  32'd0},
    '{3'd0, 2'd0, 32'((33 << 6) | 5),     4'd0,  32'd1},
    '{3'd1, 2'd0, 32'h1234_5677,          4'd2,  32'h1234_5677},
    '{3'd2, 2'd0, 32'hA5A5_0013,          4'd1,  32'hA5A5_0013},
    '{3'd2, 2'd1, 32'h0000_7007,          4'd3,  32'h0000_7007},
    '{3'd3, 2'd0, 32'h0000_1002,          4'd4,  32'h0000_1002},
    '{3'd3, 2'd1, 32'h0000_2000,          4'd5,  32'h0000_2000},
    '{3'd3, 2'd2, 32'h0000_3010,          4'd6,  32'h0000_3010},
    '{3'd3, 2'd3, 32'h0000_4020,          4'd7,  32'h0000_4020},
    '{3'd4, 2'd0, 32'h8000_0001,          4'd8,  32'h8000_0001},
    '{3'd4, 2'd1, 32'h8000_0103,          4'd9,  32'h8000_0103},
    '{3'd4, 2'd2, 32'hC000_0000,          4'd10, 32'hC000_0000},
    '{3'd4, 2'd3, 32'hC000_0008,          4'd11, 32'hC000_0008}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic inject(input vec_t v);
    @(negedge clk);
    case (v.src)
      3'd0: begin cmd_valid = 1; cmd_op = 2'd0; cmd_cfg = v.arg[11:0]; end
      3'd1: begin cmd_valid = 1; cmd_op = 2'd1; cmd_word = v.arg; host_super = 0; end
      3'd2: begin dec_req = 1; dec_bad_reg = v.kind[0]; dec_word = v.arg; end
      3'd3: begin fet_req = 1; fet_kind = v.kind; fet_pc = v.arg; end
      default: begin mem_req = 1; mem_kind = v.kind; mem_addr = v.arg; end
    endcase
    @(negedge clk);
    cmd_valid = 0; host_super = 1; dec_req = 0; fet_req = 0; mem_req = 0;
  endtask

  task automatic read(input logic [1:0] op, output logic v, output logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0;
    v = rsp_valid; d = rsp_data;
  endtask

  task automatic kill();
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd3;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic v;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 irq", 32'(irq), 0);
    check("R11 ready", 32'(vec_ready), 1);
    check("R11 rsp_valid", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);

    foreach (TBL[i]) begin
      inject(TBL[i]);
      check("R7 irq raised", 32'(irq), 1);
      check("R10 ready low", 32'(vec_ready), 0);
      read(2'd1, v, d);
      check("R8 rsp valid", 32'(v), 1);
      check("R1 cause", d, 32'(TBL[i].exp_cause));
      read(2'd2, v, d);
      check("R2 aux", d, TBL[i].exp_aux);
      kill();
      check("R9 cleared irq", 32'(irq), 0);
      check("R9 ready back", 32'(vec_ready), 1);
    end

    // R3 legal bound 32/32
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd0; cmd_cfg = 12'((32 << 6) | 32);
    #1 check("R3 cfg_ok at 32", 32'(cfg_ok), 1);
    @(negedge clk);
    cmd_valid = 0;
    check("R3 legal no trap", 32'(vec_ready), 1);

    // R3 both bad: integer flag wins
    inject('{3'd0, 2'd0, 32'((33 << 6) | 33), 4'd0, 32'd0});
    read(2'd2, v, d);
    check("R3 both bad flag", d, 0);
    // R10 config ignored while pending
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd0; cmd_cfg = 12'h001;
    #1 check("R10 cfg ignored", 32'(cfg_ok), 0);
    @(negedge clk);
    cmd_valid = 0;
    kill();

    // R6 same-cycle: fetch 5, memory 8, decode 1 -> 1
    @(negedge clk);
    fet_req = 1; fet_kind = 2'd1; fet_pc = 32'h10;
    mem_req = 1; mem_kind = 2'd0; mem_addr = 32'h20;
    dec_req = 1; dec_bad_reg = 0; dec_word = 32'h30;
    @(negedge clk);
    fet_req = 0; mem_req = 0; dec_req = 0;
    read(2'd1, v, d);
    check("R6 lowest cause", d, 1);
    read(2'd2, v, d);
    check("R6 winner aux", d, 32'h30);
    kill();

    // R5 first wins; R4 user read while pending is ignored
    inject('{3'd4, 2'd3, 32'hDEAD_0000, 4'd11, 32'hDEAD_0000});
    inject('{3'd3, 2'd0, 32'h0000_0002, 4'd4, 32'h0000_0002});
    inject('{3'd1, 2'd0, 32'h0BAD_0BAD, 4'd2, 32'h0BAD_0BAD});
    check("R4 no rsp in user", 32'(rsp_valid), 0);
    read(2'd1, v, d);
    check("R5 first cause held", d, 11);
    read(2'd2, v, d);
    check("R5 first aux held", d, 32'hDEAD_0000);

    // R7 mask gating
    @(negedge clk);
    host_im = 0;
    #1 check("R7 masked", 32'(irq), 0);
    host_im = 1;
    #1 check("R7 unmasked", 32'(irq), 1);
    kill();

    // R9 new fault after kill accepted
    inject('{3'd3, 2'd2, 32'h0000_5554, 4'd6, 32'h0000_5554});
    read(2'd1, v, d);
    check("R9 new cause after kill", d, 6);
    kill();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule